// File: doc/BRIEF.md
# Rewindable Synchronous FIFO With Fractional Occupancy Flags

This block is a single-clock first-in/first-out buffer of `DEPTH` words, each `WIDTH` bits wide (9 by default). Words enter through a write strobe and leave through a read strobe. The head word falls through to the output port combinationally. It is driven only while a read is requested, the output enable is asserted and the buffer holds data. In every other case the output bus is forced to zero, and a drive-indicator output shows when the bus carries a valid word.

Four active-low status outputs report occupancy:
- an empty flag;
- a full flag;
- a half-full flag;
- a combined edge flag, which drops both when the buffer is nearly empty and when it is nearly full.

All four are registered and follow the occupancy left by each clock edge. A rewind input returns the read side to physical location zero and leaves the write side where it is. This lets a producer that wrote at most `DEPTH` words since reset replay them from the first.

Top module: `rewind_fifo`

## Requirements
- R1: While `rst_n` is low, both pointers return to location zero, `empty_n` and `edge_n` are 0, `full_n` and `half_n` are 1, and `rd_drive` is 0.
- R2: After each clock edge, `empty_n` is 0 exactly when no word is stored, and `full_n` is 0 exactly when `DEPTH` words are stored.
- R3: `edge_n` is 0 when the stored count is below `DEPTH/8` or above `7*DEPTH/8`, and 1 for counts from `DEPTH/8` to `7*DEPTH/8` inclusive.
- R4: `half_n` is 0 exactly when the stored count exceeds `DEPTH/2`.
- R5: A read request while empty is ignored: no word is removed and nothing is driven, even when a write is accepted at the same edge.
- R6: A write request while full is ignored: the stored words and their order are unchanged.
- R7: Words leave in the order they were accepted, with write bit i appearing on output bit i. The head word is visible in the same cycle that `rd_en`, `oe` and a non-empty state coincide.
- R8: `rd_data` is all zeros and `rd_drive` is 0 unless `rd_en`, `oe` and `empty_n` are all 1. With `rd_en` at 0, `oe` has no effect.
- R9: A simultaneous accepted read and write at a count that is neither 0 nor `DEPTH` leaves the count unchanged while both pointers advance.
- R10: `rewind` high with `rd_en` low at a clock edge sets the read pointer to location zero and the count to the write pointer value, which is the number of words written since reset when that number is at most `DEPTH`. The write pointer is untouched, a write at the same edge is still accepted, and the flags are valid in the next cycle.
- R11: `rewind` asserted while `rd_en` is high has no effect; the read proceeds normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request, accepted when not full |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read request, removes the head word at the edge when not empty |
| oe | input | 1 | Output enable, effective only while `rd_en` is high |
| rewind | input | 1 | Retransmit request, honoured only while `rd_en` is low |
| rd_data | output | WIDTH | Head word when driven, zero otherwise |
| rd_drive | output | 1 | High when `rd_data` carries the head word |
| empty_n | output | 1 | Low when empty |
| full_n | output | 1 | Low when full |
| half_n | output | 1 | Low when more than half full |
| edge_n | output | 1 | Low below one eighth or above seven eighths of depth |

## Verification
A corrupted occupancy count shows first on the registered flags, at the next clock edge, and only once the count crosses one of the one-eighth, half, seven-eighths, zero or full boundaries. Long mid-level stretches therefore need boundary crossings before the fault becomes visible. A wrong read pointer is visible on `rd_data` in the same cycle that a driven read occurs, so it is caught on the first driven read after the fault. A bad rewind or a dropped full or empty block shows as a misordered or duplicated word in the replayed or drained sequence. The reference model compares every output on every cycle, so each of these faults is reported on the cycle it first reaches a port.

// File: rtl/rewind_fifo_pkg.sv
package rewind_fifo_pkg;

    typedef struct packed {
        logic empty_n;
        logic full_n;
        logic half_n;
        logic edge_n;
    } lvl_flags_t;

    localparam lvl_flags_t LVL_FLAGS_RST = '{empty_n: 1'b0, full_n: 1'b1,
                                            half_n: 1'b1, edge_n: 1'b0};

endpackage

// File: rtl/rewind_fifo_store.sv
module rewind_fifo_store #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // zero fall-through: head word is read asynchronously
    assign rdata = cells[raddr];

endmodule

// File: rtl/rewind_fifo_level.sv
module rewind_fifo_level
    import rewind_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic [CW-1:0] count,
    output lvl_flags_t    flags
);
    localparam int EIGHTH  = DEPTH / 8;
    localparam int UPPER   = DEPTH - EIGHTH;
    localparam int HALFWAY = DEPTH / 2;

    always_comb begin
        flags.empty_n = (count != '0);
        flags.full_n  = (count != CW'(DEPTH));
        flags.half_n  = !(int'(count) > HALFWAY);
        flags.edge_n  = !((int'(count) < EIGHTH) || (int'(count) > UPPER));
    end

endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo
    import rewind_fifo_pkg::*;
#(
    parameter int WIDTH = 9,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             oe,
    input  logic             rewind,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_drive,
    output logic             empty_n,
    output logic             full_n,
    output logic             half_n,
    output logic             edge_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [CW-1:0] rd_ptr;
        logic [CW-1:0] wr_ptr;
        logic [CW-1:0] count;
    } ptr_state_t;

    ptr_state_t s_q, s_d;
    lvl_flags_t flags_q, flags_d;
    logic       take_wr, take_rd, take_rw;
    logic [WIDTH-1:0] head_word;

    always_comb begin
        take_wr = wr_en && flags_q.full_n;
        take_rd = rd_en && flags_q.empty_n;
        take_rw = rewind && !rd_en;

        s_d = s_q;
        if (take_wr) begin
            s_d.wr_ptr = s_q.wr_ptr + 1'b1;
        end
        if (take_rd) begin
            s_d.rd_ptr = s_q.rd_ptr + 1'b1;
        end
        unique case ({take_wr, take_rd})
            2'b10:   s_d.count = s_q.count + 1'b1;
            2'b01:   s_d.count = s_q.count - 1'b1;
            default: s_d.count = s_q.count;
        endcase
        if (take_rw) begin
            s_d.rd_ptr = '0;
            s_d.count  = s_d.wr_ptr;
        end
    end

    rewind_fifo_level #(.DEPTH(DEPTH)) u_level (
        .count (s_d.count),
        .flags (flags_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            flags_q <= LVL_FLAGS_RST;
        end else begin
            s_q     <= s_d;
            flags_q <= flags_d;
        end
    end

    rewind_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (take_wr),
        .waddr (s_q.wr_ptr[AW-1:0]),
        .wdata (wr_data),
        .raddr (s_q.rd_ptr[AW-1:0]),
        .rdata (head_word)
    );

    assign rd_drive = rd_en && oe && flags_q.empty_n;
    assign rd_data  = rd_drive ? head_word : '0;
    assign empty_n  = flags_q.empty_n;
    assign full_n   = flags_q.full_n;
    assign half_n   = flags_q.half_n;
    assign edge_n   = flags_q.edge_n;

endmodule

// File: rtl/rewind_fifo_chk.sv
module rewind_fifo_chk #(
    parameter int WIDTH = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             oe,
    input logic             rewind,
    input logic [WIDTH-1:0] rd_data,
    input logic             rd_drive,
    input logic             empty_n,
    input logic             full_n,
    input logic             half_n,
    input logic             edge_n
);
    // R1: flags and drive held at reset values while reset is low
    always @(negedge clk) begin
        if (rst_n === 1'b0) begin
            a_r1_reset_flags: assert (!empty_n && full_n && half_n && !edge_n && !rd_drive);
        end
    end

    // R2: empty and full never both active
    a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        empty_n || full_n);

    // R4: more than half full implies not empty
    a_r4_half_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !half_n |-> empty_n);

    // R5: read while empty with no write leaves it empty
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && !wr_en && !rewind) |=> !empty_n);

    // R6: full stays full when nothing is removed
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && !rd_en && !rewind) |=> !full_n);

    // R8: output bus quiet unless read, enable and data coincide
    a_r8_output_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && oe && empty_n) |-> (!rd_drive && rd_data == '0));

endmodule

bind rewind_fifo rewind_fifo_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .oe       (oe),
    .rewind   (rewind),
    .rd_data  (rd_data),
    .rd_drive (rd_drive),
    .empty_n  (empty_n),
    .full_n   (full_n),
    .half_n   (half_n),
    .edge_n   (edge_n)
);

// File: tb/sim_rewind_fifo.sv
module sim_rewind_fifo;
    localparam int CLK_P = 10;
    localparam int W     = 9;
    localparam int D     = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, oe = 1'b0, rewind = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic rd_drive, empty_n, full_n, half_n, edge_n;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [W-1:0] q[$];
    logic [W-1:0] hist[$];

    always #(CLK_P/2) clk = ~clk;

    rewind_fifo #(.WIDTH(W), .DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .oe(oe), .rewind(rewind), .rd_data(rd_data),
        .rd_drive(rd_drive), .empty_n(empty_n), .full_n(full_n),
        .half_n(half_n), .edge_n(edge_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        int n = q.size();
        logic drv = rd_en && oe && (n > 0);
        chk("R2 empty_n", 32'(empty_n), 32'(n != 0));
        chk("R2 full_n", 32'(full_n), 32'(n != D));
        chk("R4 half_n", 32'(half_n), 32'(!(n > D/2)));
        chk("R3 edge_n", 32'(edge_n), 32'(!((n < D/8) || (n > D - D/8))));
        chk("R8 rd_drive", 32'(rd_drive), 32'(drv));
        chk("R7 rd_data", 32'(rd_data), drv ? 32'(q[0]) : 32'h0);
    endtask

    // one cycle: drive at negedge, compare, clock, update model
    task automatic cyc(input logic w, input logic [W-1:0] d, input logic r,
                       input logic o, input logic t);
        int n;
        wr_en = w; wr_data = d; rd_en = r; oe = o; rewind = t;
        #1;
        compare_all();
        @(posedge clk);
        n = q.size();
        if (r && n > 0) void'(q.pop_front());
        if (w && n < D) begin
            q.push_back(d);
            hist.push_back(d);
        end
        if (t && !r) q = hist;
        @(negedge clk);
    endtask

    task automatic peek_head(input string tag, input logic [W-1:0] exp);
        wr_en = 0; rd_en = 1; oe = 1; rewind = 0;
        #1;
        chk(tag, 32'(rd_data), 32'(exp));
    endtask

    task automatic do_reset();
        rst_n = 0; wr_en = 0; rd_en = 0; oe = 1; rewind = 0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 empty_n", 32'(empty_n), 0);
        chk("R1 full_n", 32'(full_n), 1);
        chk("R1 half_n", 32'(half_n), 1);
        chk("R1 edge_n", 32'(edge_n), 0);
        chk("R1 rd_drive", 32'(rd_drive), 0);
        q.delete();
        hist.delete();
        rst_n = 1;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R5: read while empty, also with a simultaneous write
        cyc(0, 9'h000, 1, 1, 0);
        chk("R5 still empty", 32'(empty_n), 0);
        cyc(1, 9'h0A5, 1, 1, 0);
        chk("R5 write kept", 32'(empty_n), 1);
        peek_head("R5 head after blocked read", 9'h0A5);

        // fill to full, crossing every flag boundary (R2 R3 R4)
        for (int i = 1; i < D; i++) cyc(1, 9'((i * 37 + 5) & 9'h1FF), 0, 0, 0);
        chk("R2 full reached", 32'(full_n), 0);

        // R6: write while full is dropped
        cyc(1, 9'h1AA, 0, 1, 0);
        chk("R6 still full", 32'(full_n), 0);

        // R7: read three in order with output enabled
        for (int i = 0; i < 3; i++) cyc(0, 9'h000, 1, 1, 0);

        // R11: rewind with read active acts as a plain read
        cyc(0, 9'h000, 1, 1, 1);
        peek_head("R11 head advanced", hist[4]);

        // R10: rewind restores all written words
        cyc(0, 9'h000, 0, 0, 1);
        chk("R10 full after rewind", 32'(full_n), 0);
        peek_head("R10 head is first word", hist[0]);

        // R8: drain with output enable toggling
        for (int i = 0; i < D; i++) cyc(0, 9'h000, 1, i[0], 0);
        chk("R2 drained", 32'(empty_n), 0);
        cyc(0, 9'h000, 0, 1, 0);
        chk("R8 no drive without read", 32'(rd_drive), 0);

        // R9: steady read+write at mid level
        for (int i = 0; i < 8; i++) cyc(1, 9'(9'h100 + i), 0, 0, 0);
        for (int i = 0; i < 20; i++) cyc(1, 9'(9'h040 + i), 1, 1, 0);
        chk("R9 level kept half_n", 32'(half_n), 1);
        chk("R9 level kept edge_n", 32'(edge_n), 1);
        peek_head("R9 head after mixed traffic", 9'h04C);

        // reset mid-run, then rewind with a simultaneous write (R1 R10)
        do_reset();
        for (int i = 0; i < 3; i++) cyc(1, 9'(9'h011 * (i + 1)), 0, 0, 0);
        cyc(0, 9'h000, 1, 1, 0);
        cyc(1, 9'h1F0, 0, 0, 1);
        peek_head("R10 head after rewind with write", 9'h011);
        for (int i = 0; i < 5; i++) cyc(0, 9'h000, 1, 1, 0);
        chk("R10 replay count", 32'(empty_n), 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule